// File: doc/BRIEF.md
# Sequenced Conversion Result Bank with Prioritised Interrupt Vector

This block sits behind a 12-bit converter core and owns where each result lands and how software learns about it. It holds sixteen result slots. A conversion request either targets one fixed slot or walks through the slots in order. The walk starts at a programmable slot, steps by one after every conversion, wraps from the last slot back to slot 0, and stops after the slot whose end-of-sequence bit is set. Because of this, the sixteen slots can hold several independent sequences.

Each slot has a flag. A write sets it and a read of that slot clears it. The bank also tracks two error conditions:
- Result overflow: a slot is overwritten while its previous result is still unread.
- Conversion-time overflow: a new request arrives while a conversion is still running.

All enabled pending sources are folded into one interrupt request and a priority-encoded vector. When software accesses the vector, the error condition it reports is cleared.

Top module: `conv_slot_bank`

## Requirements
- R1: With `seq_en` = 0, every accepted conversion request targets `start_slot`, and `cur_slot` shows that slot while the conversion is busy.
- R2: With `seq_en` = 1, the first conversion of a sequence targets `start_slot`. After each finished conversion whose slot has `eos_mask` bit 0, the pointer advances by one.
- R3: In a sequence, the slot after slot 15 is slot 0.
- R4: A finished conversion on a slot whose `eos_mask` bit is 1 ends the sequence. `cur_slot` stays on that slot, and the next accepted request starts again at the current `start_slot`.
- R5: `rd_data` returns the 12-bit result of slot `rd_idx` in bits 11..0, and bits 15..12 always read 0.
- R6: A slot's flag in `slot_flags` (bit k for slot k) is set when a result is written to that slot. It is cleared by the cycle in which `rd_stb` is high with `rd_idx` naming that slot.
- R7: Writing a result to a slot whose flag is still set raises the overflow condition.
- R8: A `conv_req` pulse while `busy` is high raises the time-overflow condition. Apart from that it is ignored: the running conversion keeps its slot and completes normally.
- R9: `vec` reports the highest-priority pending source that is enabled. Overflow (gated by `ovf_en`) gives 2 and has top priority. Time-overflow (gated by `tov_en`) gives 4. Slot k with its flag set and `irq_en` bit k set gives 6+2k, and a lower k wins. When nothing is enabled and pending, `vec` is 0.
- R10: A `vec_stb` cycle clears overflow if `vec` reads 2 at that time, or time-overflow if `vec` reads 4. Slot flags are never cleared by `vec_stb`.
- R11: `irq` is high whenever `vec` is nonzero. Once one source is serviced, `irq` stays or rises again if another enabled source is still pending.
- R12: After reset, all flags and both error conditions are clear, `busy` is 0, `cur_slot` is 0 and `vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_slot | input | 4 | Slot for single mode, first slot of a sequence |
| seq_en | input | 1 | 1 selects sequence stepping, 0 selects single-slot mode |
| eos_mask | input | 16 | Per-slot end-of-sequence bits |
| conv_req | input | 1 | Sample-and-convert request strobe |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | 12 | Result delivered with `conv_done` |
| rd_stb | input | 1 | Slot read strobe |
| rd_idx | input | 4 | Slot selected for reading |
| irq_en | input | 16 | Per-slot interrupt enables |
| ovf_en | input | 1 | Overflow source enable |
| tov_en | input | 1 | Time-overflow source enable |
| vec_stb | input | 1 | Vector access strobe (read or write) |
| cur_slot | output | 4 | Current slot pointer |
| busy | output | 1 | Conversion in progress |
| rd_data | output | 16 | Zero-extended result of slot `rd_idx` |
| slot_flags | output | 16 | Per-slot result-pending flags |
| irq | output | 1 | Interrupt request |
| vec | output | 6 | Encoded highest-priority source |

## Verification
- **Single-slot mode.** This is run with full-scale and small data values, which separates correct targeting from pointer drift and shows whether the upper bits of the read word are padded with zeros.
- **Sequence across the wrap.** A sequence starts at slot 13 and ends on an end bit at slot 1. This exposes a pointer that saturates instead of wrapping, and an end test applied to the wrong slot. A second sequence, started after `start_slot` changes, shows whether a finished sequence restarts at the new start or resumes from the old pointer.
- **Error and vector scenario.** Both error sources are made pending together with a slot flag. Enables are masked and the vector is accessed repeatedly. This distinguishes the priority order, the enable gating, clearing only the reported condition, and the interrupt request rising again for a source that is still pending.

// File: rtl/conv_slot_pkg.sv
package conv_slot_pkg;
   // vector codes shared by the encoder and its users
   localparam int VEC_NONE  = 0;
   localparam int VEC_OVF   = 2;
   localparam int VEC_TOV   = 4;
   localparam int VEC_SLOT0 = 6;
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
   parameter int SLOTS = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] start_slot,
   input  logic             seq_en,
   input  logic [SLOTS-1:0] eos_mask,
   input  logic             conv_req,
   input  logic             conv_done,
   output logic [IDX_W-1:0] ptr,
   output logic             busy,
   output logic             wr_en,
   output logic             tov_evt
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

   logic             in_seq;
   logic [IDX_W-1:0] ptr_next;

   assign wr_en    = conv_done & busy;
   assign tov_evt  = conv_req & busy;
   assign ptr_next = (ptr == LAST) ? '0 : IDX_W'(ptr + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         busy   <= 1'b0;
         in_seq <= 1'b0;
      end else if (conv_req && !busy) begin
         busy <= 1'b1;
         if (!(seq_en && in_seq))
            ptr <= start_slot;
      end else if (wr_en) begin
         busy <= 1'b0;
         if (seq_en && !eos_mask[ptr]) begin
            ptr    <= ptr_next;
            in_seq <= 1'b1;
         end else begin
            in_seq <= 1'b0;
         end
      end
   end

   // R1
   single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req && !busy && !seq_en |=> ptr == $past(start_slot));
   // R2
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && seq_en && !eos_mask[ptr] && ptr != LAST |=> ptr == IDX_W'($past(ptr) + 1'b1));
   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && seq_en && !eos_mask[ptr] && ptr == LAST |=> ptr == '0);
   // R8
   late_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req && busy && !conv_done |=> busy && ptr == $past(ptr));
endmodule

// File: rtl/slot_store.sv
module slot_store #(
   parameter int SLOTS  = 16,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_stb,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_value,
   output logic [SLOTS-1:0]  flags,
   output logic              ovf_evt
);
   logic [DATA_W-1:0] mem [SLOTS];
   logic              same_slot;

   assign same_slot = rd_stb && (rd_idx == wr_idx);
   assign ovf_evt   = wr_en && flags[wr_idx] && !same_slot;
   assign rd_value  = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
         flags <= '0;
      end else begin
         for (int i = 0; i < SLOTS; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
               mem[i]   <= wr_data;
               flags[i] <= 1'b1;
            end else if (rd_stb && rd_idx == IDX_W'(i)) begin
               flags[i] <= 1'b0;
            end
         end
      end
   end

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> flags[$past(wr_idx)]);
   // R6
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && !(wr_en && wr_idx == rd_idx) |=> !flags[$past(rd_idx)]);
endmodule

// File: rtl/irq_vector.sv
module irq_vector
   import conv_slot_pkg::*;
#(
   parameter int SLOTS = 16,
   parameter int VEC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] flags,
   input  logic [SLOTS-1:0] irq_en,
   input  logic             ovf_en,
   input  logic             tov_en,
   input  logic             ovf_evt,
   input  logic             tov_evt,
   input  logic             vec_stb,
   output logic [VEC_W-1:0] vec,
   output logic             irq
);
   logic             ovf_q, tov_q;
   logic [SLOTS-1:0] pend;

   assign pend = flags & irq_en;

   always_comb begin
      vec = VEC_W'(VEC_NONE);
      for (int k = SLOTS - 1; k >= 0; k--)
         if (pend[k]) vec = VEC_W'(VEC_SLOT0 + 2 * k);
      if (tov_q && tov_en) vec = VEC_W'(VEC_TOV);
      if (ovf_q && ovf_en) vec = VEC_W'(VEC_OVF);
   end

   assign irq = |vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         tov_q <= 1'b0;
      end else begin
         if (ovf_evt)                                  ovf_q <= 1'b1;
         else if (vec_stb && vec == VEC_W'(VEC_OVF))   ovf_q <= 1'b0;
         if (tov_evt)                                  tov_q <= 1'b1;
         else if (vec_stb && vec == VEC_W'(VEC_TOV))   tov_q <= 1'b0;
      end
   end

   // R7
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_q);
   // R8
   tov_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tov_evt |=> tov_q);
   // R10
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb && vec == VEC_W'(VEC_OVF) && !ovf_evt |=> !ovf_q);
   // R10
   tov_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb && vec == VEC_W'(VEC_OVF) && tov_q |=> tov_q);
endmodule

// File: rtl/conv_slot_bank.sv
module conv_slot_bank
   import conv_slot_pkg::*;
#(
   parameter int SLOTS  = 16,
   parameter int DATA_W = 12,
   parameter int WORD_W = 16,
   localparam int IDX_W = $clog2(SLOTS),
   localparam int VEC_W = $clog2(VEC_SLOT0 + 2 * SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  start_slot,
   input  logic              seq_en,
   input  logic [SLOTS-1:0]  eos_mask,
   input  logic              conv_req,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              rd_stb,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [SLOTS-1:0]  irq_en,
   input  logic              ovf_en,
   input  logic              tov_en,
   input  logic              vec_stb,
   output logic [IDX_W-1:0]  cur_slot,
   output logic              busy,
   output logic [WORD_W-1:0] rd_data,
   output logic [SLOTS-1:0]  slot_flags,
   output logic              irq,
   output logic [VEC_W-1:0]  vec
);
   if (SLOTS < 2) begin : g_bad_slots
      $error("conv_slot_bank: SLOTS must be at least 2");
   end
   if (WORD_W < DATA_W) begin : g_bad_word
      $error("conv_slot_bank: WORD_W must not be below DATA_W");
   end

   logic              wr_en, tov_evt, ovf_evt;
   logic [DATA_W-1:0] rd_value;

   slot_sequencer #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_slot(start_slot), .seq_en(seq_en),
      .eos_mask(eos_mask), .conv_req(conv_req), .conv_done(conv_done),
      .ptr(cur_slot), .busy(busy), .wr_en(wr_en), .tov_evt(tov_evt));

   slot_store #(.SLOTS(SLOTS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(cur_slot),
      .wr_data(conv_data), .rd_stb(rd_stb), .rd_idx(rd_idx),
      .rd_value(rd_value), .flags(slot_flags), .ovf_evt(ovf_evt));

   irq_vector #(.SLOTS(SLOTS), .VEC_W(VEC_W)) u_vec (
      .clk(clk), .rst_n(rst_n), .flags(slot_flags), .irq_en(irq_en),
      .ovf_en(ovf_en), .tov_en(tov_en), .ovf_evt(ovf_evt), .tov_evt(tov_evt),
      .vec_stb(vec_stb), .vec(vec), .irq(irq));

   if (WORD_W > DATA_W) begin : g_pad
      assign rd_data = {{(WORD_W - DATA_W){1'b0}}, rd_value};
   end else begin : g_exact
      assign rd_data = rd_value;
   end

   // R11
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb && irq && (|(slot_flags & irq_en)) |=> irq);
endmodule

// File: tb/conv_slot_bank_bench.sv
module conv_slot_bank_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  start_slot = '0;
   logic        seq_en = 1'b0;
   logic [15:0] eos_mask = '0;
   logic        conv_req = 1'b0;
   logic        conv_done = 1'b0;
   logic [11:0] conv_data = '0;
   logic        rd_stb = 1'b0;
   logic [3:0]  rd_idx = '0;
   logic [15:0] irq_en = '0;
   logic        ovf_en = 1'b0;
   logic        tov_en = 1'b0;
   logic        vec_stb = 1'b0;
   logic [3:0]  cur_slot;
   logic        busy;
   logic [15:0] rd_data;
   logic [15:0] slot_flags;
   logic        irq;
   logic [5:0]  vec;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   conv_slot_bank u_conv_slot_bank (
      .clk(clk), .rst_n(rst_n), .start_slot(start_slot), .seq_en(seq_en),
      .eos_mask(eos_mask), .conv_req(conv_req), .conv_done(conv_done),
      .conv_data(conv_data), .rd_stb(rd_stb), .rd_idx(rd_idx), .irq_en(irq_en),
      .ovf_en(ovf_en), .tov_en(tov_en), .vec_stb(vec_stb), .cur_slot(cur_slot),
      .busy(busy), .rd_data(rd_data), .slot_flags(slot_flags), .irq(irq), .vec(vec));

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // request, check the target slot while busy, then finish with data
   task automatic conv(input logic [11:0] d, input logic [3:0] exp_slot, input string req);
      @(negedge clk) conv_req = 1'b1;
      @(negedge clk) conv_req = 1'b0;
      chk(req, "busy slot", {28'd0, cur_slot}, {28'd0, exp_slot});
      conv_done = 1'b1;
      conv_data = d;
      @(negedge clk) conv_done = 1'b0;
   endtask

   task automatic rd(input logic [3:0] idx, input logic [15:0] exp, input string req);
      @(negedge clk) begin rd_stb = 1'b1; rd_idx = idx; end
      #1 chk(req, "read word", {16'd0, rd_data}, {16'd0, exp});
      @(negedge clk) rd_stb = 1'b0;
   endtask

   task automatic vec_access();
      @(negedge clk) vec_stb = 1'b1;
      @(negedge clk) vec_stb = 1'b0;
   endtask

   task automatic t_reset();
      chk("R12", "flags", {16'd0, slot_flags}, 32'd0);
      chk("R12", "vec", {26'd0, vec}, 32'd0);
      chk("R12", "cur_slot", {28'd0, cur_slot}, 32'd0);
      chk("R12", "busy/irq", {30'd0, busy, irq}, 32'd0);
   endtask

   task automatic t_single();
      seq_en = 1'b0; start_slot = 4'd5; irq_en = 16'hFFFF;
      conv(12'hFFF, 4'd5, "R1");
      chk("R6", "flag after write", {16'd0, slot_flags}, 32'h0020);
      chk("R9", "slot 5 code", {26'd0, vec}, 32'd16);
      chk("R11", "irq on slot", {31'd0, irq}, 32'd1);
      rd(4'd5, 16'h0FFF, "R5");
      chk("R6", "flag after read", {16'd0, slot_flags}, 32'd0);
      chk("R11", "irq idle", {31'd0, irq}, 32'd0);
      conv(12'h123, 4'd5, "R1");
      rd(4'd5, 16'h0123, "R5");
   endtask

   task automatic t_seq();
      seq_en = 1'b1; start_slot = 4'd13; eos_mask = 16'h000A; irq_en = 16'hFFFF;
      conv(12'h010, 4'd13, "R2");
      conv(12'h011, 4'd14, "R2");
      conv(12'h012, 4'd15, "R2");
      conv(12'h013, 4'd0, "R3");
      conv(12'h014, 4'd1, "R3");
      chk("R4", "pointer held at end", {28'd0, cur_slot}, 32'd1);
      chk("R6", "flags of sequence", {16'd0, slot_flags}, 32'hE003);
      chk("R9", "lowest slot wins", {26'd0, vec}, 32'd6);
      irq_en = 16'h8000;
      #1 chk("R9", "mask picks slot 15", {26'd0, vec}, 32'd36);
      irq_en = 16'hFFFF;
      start_slot = 4'd3;
      conv(12'h020, 4'd3, "R4");
      chk("R4", "one-slot sequence ends", {28'd0, cur_slot}, 32'd3);
      rd(4'd0, 16'h0013, "R5");
      chk("R9", "next slot after read", {26'd0, vec}, 32'd8);
      rd(4'd1, 16'h0014, "R5");
      rd(4'd3, 16'h0020, "R5");
      rd(4'd13, 16'h0010, "R5");
      rd(4'd14, 16'h0011, "R5");
      rd(4'd15, 16'h0012, "R5");
      chk("R6", "all read", {16'd0, slot_flags}, 32'd0);
   endtask

   task automatic t_err();
      seq_en = 1'b0; start_slot = 4'd2; irq_en = '0; ovf_en = 1'b1; tov_en = 1'b1;
      conv(12'h055, 4'd2, "R1");
      chk("R7", "no overflow on first write", {26'd0, vec}, 32'd0);
      conv(12'h066, 4'd2, "R7");
      chk("R7", "overflow code", {26'd0, vec}, 32'd2);
      @(negedge clk) conv_req = 1'b1;
      @(negedge clk) conv_req = 1'b1;
      @(negedge clk) conv_req = 1'b0;
      chk("R8", "slot kept", {30'd0, cur_slot == 4'd2, busy}, 32'd3);
      conv_done = 1'b1; conv_data = 12'h077;
      @(negedge clk) conv_done = 1'b0;
      chk("R9", "overflow outranks", {26'd0, vec}, 32'd2);
      ovf_en = 1'b0;
      #1 chk("R9", "disabled overflow skipped", {26'd0, vec}, 32'd4);
      ovf_en = 1'b1;
      vec_access();
      chk("R10", "overflow cleared", {26'd0, vec}, 32'd4);
      chk("R11", "irq stays for tov", {31'd0, irq}, 32'd1);
      vec_access();
      chk("R10", "tov cleared", {26'd0, vec}, 32'd0);
      chk("R10", "flag kept", {16'd0, slot_flags}, 32'h0004);
      irq_en = 16'h0004;
      #1 chk("R11", "irq rises again", {26'd0, irq, vec[4:0]}, {26'd0, 1'b1, 5'd10});
      rd(4'd2, 16'h0077, "R8");
      chk("R11", "all serviced", {26'd0, vec}, 32'd0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_single();
            t_seq();
            t_err();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule